// File: doc/BRIEF.md
# Endpoint FIFO Flag and Flush Unit

This block keeps an occupancy count for each of four endpoint FIFOs, numbered 2, 4, 6 and 8. From each count it derives an empty flag, a full flag and a programmable-level flag, and it packs these flags into two byte-wide status registers. An external master reads them through a small register port. The FIFO storage and the transfer engine live elsewhere. They report data movement to this block through per-endpoint write and read strobes.

The master can also write a control register. The upper nibble of that register is a flush bitmask, and one write can clear any set of FIFOs. The lower nibble is not a mask: it holds an endpoint number. Writing that number commits the partly filled IN packet of that endpoint to the host, which the block signals with a one-cycle commit pulse. Each endpoint also has an early-flag mode, which moves its empty and full thresholds one entry inward. This gives the consumer and producer a cycle of warning.

Endpoint index order on all vector ports is: index 0 for endpoint 2, index 1 for endpoint 4, index 2 for endpoint 6, and index 3 for endpoint 8.

Top module: `efifo_flag_unit`

## Requirements
- R1: Register address 0 reads status byte A. Endpoint 4's programmable, empty and full flags sit in bits 6, 5 and 4. Endpoint 2's same three flags sit in bits 2, 1 and 0. Bits 7 and 3 read 0.
- R2: Register address 1 reads status byte B. It has the same layout as status byte A, with endpoint 8 in bits 6..4 and endpoint 6 in bits 2..0.
- R3: With early mode off, an endpoint's empty flag is 1 exactly when its occupancy is 0. Its full flag is 1 exactly when its occupancy equals DEPTH.
- R4: After reset, every occupancy is 0. With nonzero thresholds, both status bytes read 0x22. The flush pulses, commit pulses and error bits are all 0. Address 2, the write-only control register, reads 0.
- R5: With an endpoint's early-mode bit set, its empty flag is 1 when occupancy is 1 or less, and its full flag is 1 when occupancy is DEPTH-1 or more.
- R6: A write to address 2 flushes endpoints 8, 6, 4 and 2 for data bits 7, 6, 5 and 4 respectively, in any combination. In the cycle after the write, each flushed endpoint has occupancy 0 and its empty flag is 1, and its flush_pulse bit is high for exactly that one cycle. A flush overrides strobes to that endpoint in the same cycle.
- R7: A write to address 2 whose bits 3..0 hold 2, 4, 6 or 8 raises the matching commit_pulse bit for the one cycle after the write. This works alongside any flush bits in the same write.
- R8: Any other value in bits 3..0, including 0, raises no commit pulse and leaves every flag unchanged.
- R9: An endpoint's programmable flag is 1 when its occupancy is greater than or equal to its prog_level input.
- R10: An accepted write strobe adds one to occupancy. An accepted read strobe subtracts one. When both are accepted in the same cycle, occupancy is unchanged.
- R11: A write strobe at occupancy DEPTH and a read strobe at occupancy 0 are ignored. Either one sets that endpoint's sticky error bit, which only reset clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 4 | Per-endpoint write strobe (data entered FIFO) |
| rd_stb | input | 4 | Per-endpoint read strobe (data left FIFO) |
| prog_level | input | 4 x OCC_W | Per-endpoint programmable-flag threshold |
| early_mode | input | 4 | Per-endpoint early-flag mode |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (0 status A, 1 status B, 2 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| flag_empty | output | 4 | Empty flags |
| flag_full | output | 4 | Full flags |
| flag_prog | output | 4 | Programmable-level flags |
| err_sticky | output | 4 | Sticky overflow/underflow error bits |
| flush_pulse | output | 4 | One-cycle flush indication per endpoint |
| commit_pulse | output | 4 | One-cycle IN packet commit per endpoint |

## Verification
Each flag is a pure function of its occupancy counter, so a count that is off by one shows up at the ports as soon as the count crosses a threshold. It appears as an empty, full or programmable flag one cycle early or one cycle late. A lost flush leaves the empty flag low in the cycle where the flush pulse is high. A count that wraps past DEPTH shows up as an empty and full pattern that does not match the number of writes the bench has counted. A miswired status byte shows up on the first register read, because each table step compares both bytes against hand-computed values.

// File: rtl/efu_pkg.sv
package efu_pkg;

    localparam int NUM_EP = 4;

    localparam logic [1:0] ADDR_STAT_A = 2'd0;
    localparam logic [1:0] ADDR_STAT_B = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

    // Bit order gives positions 2,1,0 within a status half-byte
    typedef struct packed {
        logic prog;
        logic empty;
        logic full;
    } ep_flags_t;

    typedef struct packed {
        logic [3:0] flush_mask;
        logic [3:0] ep_num;
    } ctrl_word_t;

    // Endpoint number in the lower nibble -> one-hot endpoint index
    function automatic logic [NUM_EP-1:0] commit_decode(input logic [3:0] ep_num);
        logic [NUM_EP-1:0] hot;
        hot = '0;
        case (ep_num)
            4'd2:    hot[0] = 1'b1;
            4'd4:    hot[1] = 1'b1;
            4'd6:    hot[2] = 1'b1;
            4'd8:    hot[3] = 1'b1;
            default: hot = '0;
        endcase
        return hot;
    endfunction

    function automatic logic [7:0] pack_pair(input ep_flags_t upper, input ep_flags_t lower);
        return {1'b0, upper, 1'b0, lower};
    endfunction

endpackage

// File: rtl/efu_ep_tracker.sv
module efu_ep_tracker
    import efu_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  logic             flush,
    input  logic             early,
    input  logic [OCC_W-1:0] level,
    output logic [OCC_W-1:0] occ,
    output ep_flags_t        flags,
    output logic             err
);

    localparam logic [OCC_W-1:0] CAP      = OCC_W'(DEPTH);
    localparam logic [OCC_W-1:0] CAP_LESS = OCC_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] ONE      = OCC_W'(1);

    logic [OCC_W-1:0] occ_q;
    logic             at_cap;
    logic             at_zero;
    logic             wr_ok;
    logic             rd_ok;
    logic             err_q;

    assign at_cap  = (occ_q == CAP);
    assign at_zero = (occ_q == '0);
    assign wr_ok   = wr && !at_cap;
    assign rd_ok   = rd && !at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
        end else if (flush) begin
            occ_q <= '0;
        end else begin
            case ({wr_ok, rd_ok})
                2'b10:   occ_q <= occ_q + ONE;
                2'b01:   occ_q <= occ_q - ONE;
                default: occ_q <= occ_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if ((wr && at_cap) || (rd && at_zero)) begin
            err_q <= 1'b1;
        end
    end

    always_comb begin
        flags.prog  = (occ_q >= level);
        flags.empty = early ? (occ_q <= ONE) : at_zero;
        flags.full  = early ? (occ_q >= CAP_LESS) : at_cap;
    end

    assign occ = occ_q;
    assign err = err_q;

endmodule

// File: rtl/efu_ctrl_decode.sv
module efu_ctrl_decode
    import efu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [NUM_EP-1:0] flush_req,
    output logic [NUM_EP-1:0] flush_pulse,
    output logic [NUM_EP-1:0] commit_pulse
);

    ctrl_word_t        word;
    logic              hit;
    logic [NUM_EP-1:0] commit_req;
    logic [NUM_EP-1:0] flush_q;
    logic [NUM_EP-1:0] commit_q;

    assign word       = ctrl_word_t'(reg_wdata);
    assign hit        = reg_we && (reg_addr == ADDR_CTRL);
    // Upper-nibble bits 4..7 already line up with indices 0..3 (ep 2,4,6,8)
    assign flush_req  = hit ? word.flush_mask : '0;
    assign commit_req = hit ? commit_decode(word.ep_num) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_q  <= '0;
            commit_q <= '0;
        end else begin
            flush_q  <= flush_req;
            commit_q <= commit_req;
        end
    end

    assign flush_pulse  = flush_q;
    assign commit_pulse = commit_q;

endmodule

// File: rtl/efu_status_mux.sv
module efu_status_mux
    import efu_pkg::*;
(
    input  ep_flags_t [NUM_EP-1:0] flags,
    input  logic [1:0]             reg_addr,
    output logic [7:0]             reg_rdata
);

    logic [7:0] byte_a;
    logic [7:0] byte_b;

    assign byte_a = pack_pair(flags[1], flags[0]);
    assign byte_b = pack_pair(flags[3], flags[2]);

    always_comb begin
        case (reg_addr)
            ADDR_STAT_A: reg_rdata = byte_a;
            ADDR_STAT_B: reg_rdata = byte_b;
            default:     reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/efifo_flag_unit.sv
module efifo_flag_unit
    import efu_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_EP-1:0]            wr_stb,
    input  logic [NUM_EP-1:0]            rd_stb,
    input  logic [NUM_EP-1:0][OCC_W-1:0] prog_level,
    input  logic [NUM_EP-1:0]            early_mode,
    input  logic                         reg_we,
    input  logic [1:0]                   reg_addr,
    input  logic [7:0]                   reg_wdata,
    output logic [7:0]                   reg_rdata,
    output logic [NUM_EP-1:0]            flag_empty,
    output logic [NUM_EP-1:0]            flag_full,
    output logic [NUM_EP-1:0]            flag_prog,
    output logic [NUM_EP-1:0]            err_sticky,
    output logic [NUM_EP-1:0]            flush_pulse,
    output logic [NUM_EP-1:0]            commit_pulse
);

    logic [NUM_EP-1:0]            flush_req;
    logic [NUM_EP-1:0][OCC_W-1:0] occ;
    ep_flags_t [NUM_EP-1:0]       flags;

    efu_ctrl_decode u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .flush_req    (flush_req),
        .flush_pulse  (flush_pulse),
        .commit_pulse (commit_pulse)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        efu_ep_tracker #(
            .DEPTH (DEPTH),
            .OCC_W (OCC_W)
        ) u_trk (
            .clk   (clk),
            .rst   (rst),
            .wr    (wr_stb[i]),
            .rd    (rd_stb[i]),
            .flush (flush_req[i]),
            .early (early_mode[i]),
            .level (prog_level[i]),
            .occ   (occ[i]),
            .flags (flags[i]),
            .err   (err_sticky[i])
        );
        assign flag_empty[i] = flags[i].empty;
        assign flag_full[i]  = flags[i].full;
        assign flag_prog[i]  = flags[i].prog;
    end

    efu_status_mux u_mux (
        .flags     (flags),
        .reg_addr  (reg_addr),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/efu_checker.sv
module efu_checker
    import efu_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OCC_W = $clog2(DEPTH + 1)
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_EP-1:0]            wr_stb,
    input logic [NUM_EP-1:0]            rd_stb,
    input logic [NUM_EP-1:0]            flush_req,
    input logic [NUM_EP-1:0][OCC_W-1:0] occ,
    input logic [NUM_EP-1:0]            flag_empty,
    input logic [NUM_EP-1:0]            flag_full,
    input logic [NUM_EP-1:0]            err_sticky,
    input logic [NUM_EP-1:0]            flush_pulse,
    input logic [NUM_EP-1:0]            commit_pulse
);

    localparam logic [OCC_W-1:0] CAP = OCC_W'(DEPTH);

    p_one_commit_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(commit_pulse));

    for (genvar i = 0; i < NUM_EP; i++) begin : g_chk
        p_flush_empties_r6: assert property (@(posedge clk) disable iff (rst)
            flush_pulse[i] |-> flag_empty[i]);

        p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
            occ[i] <= CAP);

        p_err_holds_r11: assert property (@(posedge clk) disable iff (rst)
            err_sticky[i] |=> err_sticky[i]);

        p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
            (!wr_stb[i] && !rd_stb[i] && !flush_req[i]) |=> $stable(occ[i]));

        p_not_both_r3: assert property (@(posedge clk) disable iff (rst)
            !(flag_empty[i] && flag_full[i]));
    end

endmodule

bind efifo_flag_unit efu_checker #(
    .DEPTH (DEPTH),
    .OCC_W (OCC_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_stb       (wr_stb),
    .rd_stb       (rd_stb),
    .flush_req    (flush_req),
    .occ          (occ),
    .flag_empty   (flag_empty),
    .flag_full    (flag_full),
    .err_sticky   (err_sticky),
    .flush_pulse  (flush_pulse),
    .commit_pulse (commit_pulse)
);

// File: tb/efifo_flag_unit_tb.sv
`timescale 1ns/100ps
module efifo_flag_unit_tb;
    import efu_pkg::*;

    localparam int DEPTH = 16;
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic [NUM_EP-1:0]            wr_stb = '0;
    logic [NUM_EP-1:0]            rd_stb = '0;
    logic [NUM_EP-1:0][OCC_W-1:0] prog_level;
    logic [NUM_EP-1:0]            early_mode = '0;
    logic                         reg_we = 1'b0;
    logic [1:0]                   reg_addr = 2'd0;
    logic [7:0]                   reg_wdata = 8'h00;
    logic [7:0]                   reg_rdata;
    logic [NUM_EP-1:0]            flag_empty, flag_full, flag_prog;
    logic [NUM_EP-1:0]            err_sticky, flush_pulse, commit_pulse;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    efifo_flag_unit #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .prog_level(prog_level), .early_mode(early_mode),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .flag_empty(flag_empty), .flag_full(flag_full),
        .flag_prog(flag_prog), .err_sticky(err_sticky),
        .flush_pulse(flush_pulse), .commit_pulse(commit_pulse)
    );

    // {wr mask, rd mask, expected status A, expected status B}; thresholds 3
    localparam logic [23:0] VEC [0:7] = '{
        24'h10_20_22, 24'h30_00_22, 24'h10_04_22, 24'h11_04_22,
        24'h02_24_22, 24'h02_24_22, 24'hC0_24_00, 24'h01_20_00
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic cyc(input logic [3:0] w, input logic [3:0] r);
        @(negedge clk);
        wr_stb = w;
        rd_stb = r;
        @(posedge clk);
        #1;
        wr_stb = '0;
        rd_stb = '0;
    endtask

    task automatic wctl(input logic [7:0] b, input logic [3:0] w);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = ADDR_CTRL;
        reg_wdata = b;
        wr_stb = w;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        wr_stb = '0;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < NUM_EP; i++) prog_level[i] = OCC_W'(3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R4 reset state
        rdreg(ADDR_STAT_A, d); chk("R4 status A at reset", d, 8'h22);
        rdreg(ADDR_STAT_B, d); chk("R4 status B at reset", d, 8'h22);
        rdreg(ADDR_CTRL, d);   chk("R4 control reads zero", d, 8'h00);
        chk("R4 pulses idle", {flush_pulse, commit_pulse}, 8'h00);
        chk("R4 errors clear", {4'h0, err_sticky}, 8'h00);

        // R1 R2 R3 R9 R10 table walk
        for (int k = 0; k < 8; k++) begin
            cyc(VEC[k][23:20], VEC[k][19:16]);
            rdreg(ADDR_STAT_A, d); chk($sformatf("R1 R10 step %0d A", k), d, VEC[k][15:8]);
            rdreg(ADDR_STAT_B, d); chk($sformatf("R2 R10 step %0d B", k), d, VEC[k][7:0]);
        end
        chk("R11 underflow error on ep4", {4'h0, err_sticky}, 8'h02);

        // R3 fill ep2 (occ 2) to capacity
        for (int k = 0; k < 13; k++) cyc(4'b0001, 4'b0000);
        chk("R3 full low at DEPTH-1", {7'd0, flag_full[0]}, 8'h00);
        cyc(4'b0001, 4'b0000);
        rdreg(ADDR_STAT_A, d); chk("R3 R1 full at DEPTH", d, 8'h25);
        cyc(4'b0001, 4'b0000);
        rdreg(ADDR_STAT_A, d); chk("R11 write at full ignored", d, 8'h25);
        chk("R11 overflow error on ep2", {4'h0, err_sticky}, 8'h03);
        cyc(4'b0000, 4'b0001);
        rdreg(ADDR_STAT_A, d); chk("R10 read from full", d, 8'h24);

        // R5 early mode
        early_mode[0] = 1'b1;
        #0.5;
        rdreg(ADDR_STAT_A, d); chk("R5 early full at DEPTH-1", d, 8'h25);
        for (int k = 0; k < 14; k++) cyc(4'b0000, 4'b0001);
        rdreg(ADDR_STAT_A, d); chk("R5 early empty at one", d, 8'h22);
        early_mode[0] = 1'b0;
        rdreg(ADDR_STAT_A, d); chk("R3 normal empty low at one", d, 8'h20);

        // R9 threshold change on ep6 (occ 1)
        prog_level[2] = OCC_W'(1);
        rdreg(ADDR_STAT_B, d); chk("R9 prog at level equal", d, 8'h04);
        prog_level[2] = OCC_W'(3);

        // R6 flush ep8 and ep2, with a competing write to ep2
        wctl(8'h90, 4'b0001);
        chk("R6 flush pulse", {4'h0, flush_pulse}, 8'h09);
        chk("R6 empty after flush", {4'h0, flag_empty}, 8'h0B);
        chk("R8 no commit on zero", {4'h0, commit_pulse}, 8'h00);
        @(posedge clk); #1;
        chk("R6 flush pulse one cycle", {4'h0, flush_pulse}, 8'h00);

        // R7 commit decode
        wctl(8'h06, 4'b0000); chk("R7 commit ep6", {4'h0, commit_pulse}, 8'h04);
        rdreg(ADDR_STAT_B, d); chk("R7 flags untouched", d, 8'h20);
        wctl(8'h08, 4'b0000); chk("R7 commit ep8", {4'h0, commit_pulse}, 8'h08);
        wctl(8'h02, 4'b0000); chk("R7 commit ep2", {4'h0, commit_pulse}, 8'h01);
        wctl(8'h04, 4'b0000); chk("R7 commit ep4", {4'h0, commit_pulse}, 8'h02);
        @(posedge clk); #1;
        chk("R7 commit one cycle", {4'h0, commit_pulse}, 8'h00);

        // R8 invalid numbers
        wctl(8'h05, 4'b0000); chk("R8 value 5 no commit", {4'h0, commit_pulse}, 8'h00);
        wctl(8'h0A, 4'b0000); chk("R8 value 10 no commit", {4'h0, commit_pulse}, 8'h00);
        rdreg(ADDR_STAT_B, d); chk("R8 flags unchanged", d, 8'h20);

        // R6 R7 combined flush and commit
        wctl(8'h26, 4'b0000);
        chk("R6 combined flush ep4", {4'h0, flush_pulse}, 8'h02);
        chk("R7 combined commit ep6", {4'h0, commit_pulse}, 8'h04);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule